// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block raises a prioritized interrupt request at a fixed programmable interval. Software programs three registers through a plain write port: a control register that carries a 3-bit priority level and an 8-bit vector, a timer register that carries an 8-bit modulus and a prescale select, and an autovector mask that holds one bit per priority level. Once the timer is started, a prescaler divides the reference clock by 4, or by 4 x 512 when the prescale select is set. Each prescaler tick decrements a down-counter. When the counter reaches zero it reloads from the modulus and flags an interrupt.

The request is held pending until the interrupt controller pulses the acknowledge input. While the request is pending, the block presents the level. It also either supplies the programmed vector or asks for an autovectored acknowledge, according to the mask bit for that level. A module-wide freeze input halts counting without losing state. Every port is a plain control or status pin, so the block has no flow-controlled stream and no back-pressure rules.

Top module: `pit_timer_top`

## Requirements
- R1: After reset, `irq_req`, `irq_level`, `irq_vector` and `irq_autovec` are all 0. The timer stays stopped, so no request appears until the timer register is written.
- R2: With the prescale select clear, writing the timer register (`wr_sel`=1) with a nonzero modulus N in `wr_data[7:0]` restarts the count. `irq_req` rises after exactly 4*N rising clock edges following the write edge.
- R3: With the prescale select set (`wr_data[8]`=1 in the timer write), the interval becomes 2048*N clock edges.
- R4: At each zero the counter reloads from the modulus, so further requests are flagged every interval for as long as the timer runs.
- R5: Writing the timer register with a modulus of 0 stops the timer, and no further request is flagged.
- R6: The level is `wr_data[10:8]` of a control write (`wr_sel`=0) and the vector is `wr_data[7:0]`. Reset gives level 0 and vector 0x0F. Level 0 never raises a request and drops any request that is pending.
- R7: While `freeze` is high, the prescaler and the counter hold, so each frozen edge delays the next request by one edge. A nonzero timer write made while frozen stores the value but does not start the timer.
- R8: The autovector mask is `wr_data[15:8]` of a write with `wr_sel`=2. If mask bit `level` is set, a pending request drives `irq_autovec`=1 and `irq_vector`=0. Otherwise it drives `irq_autovec`=0 and `irq_vector` equal to the programmed vector.
- R9: A pending request stays high through later zeros until `irq_ack` is high at a rising edge, and it is low after that edge. While a request is pending, `irq_level` shows the programmed level; at all other times it is 0.
- R10: If a zero and an acknowledge fall on the same edge, the request remains pending.
- R11: A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 timer, 2 autovector mask, 3 none |
| wr_data | input | 16 | Write data |
| freeze | input | 1 | Module-wide freeze; halts the timer while high |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Pending interrupt request |
| irq_level | output | 3 | Priority level of the pending request |
| irq_vector | output | 8 | Supplied vector, 0 when autovectored or idle |
| irq_autovec | output | 1 | Pending request wants an autovectored acknowledge |

## Verification
A request becomes visible just after the 4*N-th (or 2048*N-th) unfrozen rising edge that follows the timer write edge. An acknowledge clears the request after the single edge that samples it, and register writes take effect on the edge that captures them. The bench drives every input on the falling edge and advances one rising edge at a time. It keeps a cycle model with an active-edge count that skips frozen edges, plus a pending flag. Each falling edge it compares all four outputs with that model, so an early or late request by even one edge is reported.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int REG_W    = 16;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int LVL_LSB  = 8;
  localparam int MASK_LSB = 8;
  localparam int NLEVELS  = 1 << LVL_W;
  localparam logic [VEC_W-1:0] VEC_RST = 8'h0F;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_TIMER = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } pit_sel_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int MOD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               freeze,
  output logic [LVL_W-1:0]   level,
  output logic [VEC_W-1:0]   vector,
  output logic [MOD_W-1:0]   modulus,
  output logic               slow,
  output logic [NLEVELS-1:0] avmask,
  output logic               start,
  output logic               stop,
  output logic [MOD_W-1:0]   load_val
);
  logic sel_ctrl, sel_timer, sel_mask;

  assign sel_ctrl  = wr_en && (pit_sel_e'(wr_sel) == SEL_CTRL);
  assign sel_timer = wr_en && (pit_sel_e'(wr_sel) == SEL_TIMER);
  assign sel_mask  = wr_en && (pit_sel_e'(wr_sel) == SEL_MASK);
  assign load_val  = wr_data[MOD_W-1:0];
  assign start     = sel_timer && (load_val != '0) && !freeze;
  assign stop      = sel_timer && (load_val == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level   <= '0;
      vector  <= VEC_RST;
      modulus <= '0;
      slow    <= 1'b0;
      avmask  <= '0;
    end else begin
      if (sel_ctrl) begin
        level  <= wr_data[LVL_LSB +: LVL_W];
        vector <= wr_data[VEC_W-1:0];
      end
      if (sel_timer) begin
        modulus <= load_val;
        slow    <= wr_data[MOD_W];
      end
      if (sel_mask) avmask <= wr_data[MASK_LSB +: NLEVELS];
    end
  end
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int BASE_DIV = 4,
  parameter int SLOW_DIV = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic slow,
  output logic tick
);
  localparam int FULL_DIV = BASE_DIV * SLOW_DIV;
  localparam int PW       = $clog2(FULL_DIV);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;

  assign limit = slow ? PW'(FULL_DIV - 1) : PW'(BASE_DIV - 1);
  assign tick  = en && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (en)       cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [MOD_W-1:0] load_val,
  input  logic [MOD_W-1:0] modulus,
  input  logic             tick,
  input  logic             freeze,
  output logic             en,
  output logic             zero_evt,
  output logic [MOD_W-1:0] cnt_q
);
  logic running;

  assign en       = running && !freeze;
  assign zero_evt = tick && (cnt_q == MOD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt_q   <= load_val;
    end else if (stop) begin
      running <= 1'b0;
    end else if (tick) begin
      cnt_q <= zero_evt ? modulus : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pit_irq.sv
module pit_irq
  import pit_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_evt,
  input  logic               ack,
  input  logic [LVL_W-1:0]   level,
  input  logic [VEC_W-1:0]   vector,
  input  logic [NLEVELS-1:0] avmask,
  output logic               req,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               av_o
);
  logic pend_q, pend_d, av_sel;

  always_comb begin
    if (level == '0)   pend_d = 1'b0;
    else if (zero_evt) pend_d = 1'b1;
    else if (ack)      pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign av_sel = avmask[level];
  assign req    = pend_q;
  assign lvl_o  = pend_q ? level : '0;
  assign av_o   = pend_q && av_sel;
  assign vec_o  = (pend_q && !av_sel) ? vector : '0;
endmodule

// File: rtl/pit_timer_top.sv
module pit_timer_top
  import pit_pkg::*;
#(
  parameter int BASE_DIV = 4,
  parameter int SLOW_DIV = 512,
  parameter int MOD_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               freeze,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [LVL_W-1:0]   irq_level,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               irq_autovec
);
  logic [LVL_W-1:0]   level;
  logic [VEC_W-1:0]   vector;
  logic [MOD_W-1:0]   modulus, load_val, cnt_q;
  logic [NLEVELS-1:0] avmask;
  logic slow, start, stop, en, tick, zero_evt;

  pit_regs #(.MOD_W(MOD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .freeze(freeze), .level(level), .vector(vector),
    .modulus(modulus), .slow(slow), .avmask(avmask), .start(start),
    .stop(stop), .load_val(load_val)
  );

  pit_prescaler #(.BASE_DIV(BASE_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(start || stop), .en(en),
    .slow(slow), .tick(tick)
  );

  pit_counter #(.MOD_W(MOD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .load_val(load_val), .modulus(modulus), .tick(tick), .freeze(freeze),
    .en(en), .zero_evt(zero_evt), .cnt_q(cnt_q)
  );

  pit_irq u_irq (
    .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .ack(irq_ack),
    .level(level), .vector(vector), .avmask(avmask), .req(irq_req),
    .lvl_o(irq_level), .vec_o(irq_vector), .av_o(irq_autovec)
  );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int MOD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             freeze,
  input logic             irq_ack,
  input logic             irq_req,
  input logic [2:0]       irq_level,
  input logic [7:0]       irq_vector,
  input logic             irq_autovec,
  input logic             zero_evt,
  input logic [MOD_W-1:0] cnt_q
);
  logic timer_wr;
  assign timer_wr = wr_en && (wr_sel == 2'd1);

  // R2: a request only appears after a counter zero
  p_rise_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(zero_evt));

  // R6: a pending request never carries level 0
  p_level_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != 3'd0));

  // R7: frozen counter holds its value
  p_freeze_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !timer_wr) |=> $stable(cnt_q));

  // R8: autovectored request supplies no vector
  p_autovec_novec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_autovec |-> (irq_req && irq_vector == 8'd0));

  // R9: pending stays until acknowledged
  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && irq_level != 3'd0) |=> irq_req);

  // R9: acknowledge without a coinciding zero clears the request
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !zero_evt) |=> !irq_req);
endmodule

bind pit_timer_top pit_timer_chk #(.MOD_W(MOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .freeze(freeze), .irq_ack(irq_ack), .irq_req(irq_req),
  .irq_level(irq_level), .irq_vector(irq_vector),
  .irq_autovec(irq_autovec), .zero_evt(zero_evt), .cnt_q(cnt_q)
);

// File: tb/pit_timer_top_tb.sv
module pit_timer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        freeze = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req, irq_autovec;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  int       m_act, m_per;
  bit       m_pend;
  bit [2:0] m_lvl;
  bit [7:0] m_vec, m_avm;

  always #4 clk = ~clk;

  pit_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .freeze(freeze), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
    .irq_autovec(irq_autovec)
  );

  function automatic int period(input int n, input bit slow);
    return slow ? n * 2048 : n * 4;
  endfunction

  function automatic bit [12:0] expect_out(input bit pend, input bit [2:0] lvl,
                                           input bit [7:0] vec, input bit [7:0] avm);
    bit av;
    av = pend && avm[lvl];
    return {pend, pend ? lvl : 3'd0, (pend && !av) ? vec : 8'd0, av};
  endfunction

  task automatic check_out(input string req, input bit [12:0] exp);
    bit [12:0] act;
    act = {irq_req, irq_level, irq_vector, irq_autovec};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual req=%b lvl=%0d vec=%h av=%b expected req=%b lvl=%0d vec=%h av=%b",
               req, $time, act[12], act[11:9], act[8:1], act[0],
               exp[12], exp[11:9], exp[8:1], exp[0]);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // one edge with given ack/freeze, update model, then compare
  task automatic step_model(input bit ack_v, input bit frz_v, input string req);
    bit zero;
    irq_ack = ack_v; freeze = frz_v;
    @(posedge clk);
    zero = 1'b0;
    if (!frz_v && m_per > 0) begin
      m_act++;
      zero = (m_act % m_per) == 0;
    end
    if (m_lvl == 3'd0)    m_pend = 1'b0;
    else if (zero)        m_pend = 1'b1;
    else if (ack_v)       m_pend = 1'b0;
    @(negedge clk);
    irq_ack = 1'b0; freeze = 1'b0;
    check_out(req, expect_out(m_pend, m_lvl, m_vec, m_avm));
  endtask

  task automatic setup(input bit [2:0] lvl, input bit [7:0] vec, input bit [7:0] avm);
    wr(2'd1, 16'h0000);           // stop (R5)
    irq_ack = 1'b1; idle(1); irq_ack = 1'b0;
    wr(2'd0, {5'd0, lvl, vec});
    wr(2'd2, {avm, 8'h00});
    m_lvl = lvl; m_vec = vec; m_avm = avm; m_pend = 1'b0; m_per = 0; m_act = 0;
  endtask

  task automatic start_timer(input int n, input bit slow);
    wr(2'd1, {7'd0, slow, n[7:0]});
    m_per = period(n, slow); m_act = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_out("R1 reset outputs", 13'd0);
    wr(2'd0, 16'h0305);
    wr(2'd2, 16'h0000);
    idle(200);
    check_out("R1 stopped after reset", 13'd0);

    // R11: select 3 ignored; level stays 3, vector 0x05
    wr(2'd3, 16'hFFFF);
    m_lvl = 3'd3; m_vec = 8'h05; m_avm = 8'h00; m_pend = 1'b0;
    start_timer(2, 1'b0);
    idle(7);
    check_out("R2 low before 8 edges", 13'd0);
    idle(1);
    check_out("R11 R2 rise at 8 edges, regs untouched", expect_out(1'b1, 3'd3, 8'h05, 8'h00));

    // R2 R4: directed N=5, then periodic repeat
    setup(3'd2, 8'h5A, 8'h00);
    start_timer(5, 1'b0);
    for (int i = 0; i < 19; i++) step_model(1'b0, 1'b0, "R2 before first zero");
    step_model(1'b0, 1'b0, "R2 first zero at 20");
    step_model(1'b1, 1'b0, "R9 ack clears");
    for (int i = 0; i < 19; i++) step_model(1'b0, 1'b0, "R4 reload repeat");
    // R9: hold through another zero without ack
    for (int i = 0; i < 25; i++) step_model(1'b0, 1'b0, "R9 held pending");
    step_model(1'b1, 1'b0, "R9 ack after hold");

    // R8: autovector for level 4
    setup(3'd4, 8'hC3, 8'h10);
    start_timer(3, 1'b0);
    for (int i = 0; i < 14; i++) step_model(1'b0, 1'b0, "R8 autovectored");

    // R10: ack held through the zero edge, N=1
    setup(3'd1, 8'h22, 8'h00);
    start_timer(1, 1'b0);
    for (int i = 0; i < 12; i++) step_model(1'b1, 1'b0, "R10 ack on zero edge");

    // R6: level 0 never requests
    setup(3'd0, 8'h11, 8'hFF);
    start_timer(2, 1'b0);
    for (int i = 0; i < 30; i++) step_model(1'b0, 1'b0, "R6 level zero");

    // R5: stop mid-count
    setup(3'd5, 8'h33, 8'h00);
    start_timer(4, 1'b0);
    idle(10);
    wr(2'd1, 16'h0000);
    idle(40);
    check_out("R5 stopped no request", 13'd0);

    // R7: frozen write does not start
    freeze = 1'b1;
    wr(2'd1, 16'h0002);
    freeze = 1'b0;
    idle(40);
    check_out("R7 frozen write no start", 13'd0);

    // R7: freeze delays by frozen edges
    setup(3'd6, 8'h44, 8'h00);
    start_timer(3, 1'b0);
    for (int i = 0; i < 30; i++) step_model(1'b0, (i >= 4 && i < 9), "R7 freeze delay");

    // R3: slow prescale, N=2 -> 4096 edges
    setup(3'd7, 8'h77, 8'h00);
    start_timer(2, 1'b1);
    idle(4095);
    check_out("R3 low before 4096", 13'd0);
    idle(1);
    check_out("R3 rise at 4096", expect_out(1'b1, 3'd7, 8'h77, 8'h00));

    // constrained random trials: R2 R4 R6 R7 R8 R9 R10
    for (int t = 0; t < 14; t++) begin
      bit [2:0] lv;
      int n;
      lv = 3'($urandom_range(7, 0));
      n  = $urandom_range(12, 1);
      setup(lv, 8'($urandom), 8'($urandom));
      start_timer(n, 1'b0);
      for (int i = 0; i < 12 * n + 6; i++)
        step_model($urandom_range(99, 0) < 15, $urandom_range(99, 0) < 10,
                   "R2 R4 R8 R9 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule